// File: doc/BRIEF.md
# Sync period meter

This block times the horizontal and vertical sync inputs of a video stream in oscillator clock cycles. Each sync input first passes a glitch filter. The filter synchronizes the input and accepts a new level only when two successive samples agree. Each filtered input then feeds a measurement channel. That channel counts cycles between rising edges, saturates instead of wrapping, tracks whether the input is alive, and judges polarity by comparing high time against low time.

The horizontal channel times a window of 64 line periods with a 15-bit count and keeps the top 11 bits. This equals four times the line period in cycles. The vertical channel times one frame period with a 14-bit count and keeps the top 9 bits. The vertical reference is either the dedicated vertical input or an extracted composite vertical pulse, chosen by `vsel_i`. When the composite path is chosen, its presence comes from the separator through `cv_present_i`. The horizontal result follows one of two update rules. While a vertical reference is present, it loads once per frame on the reference's rising edge. Otherwise it loads at the end of every 64-line window.

Top module: `sync_meas`

## Requirements
- R1: A change of level on a sync input is accepted only after it has been seen on two consecutive synchronized samples. A pulse lasting a single clock cycle has no effect on any output.
- R2: With a steady line period P, `hperiod_o` equals bits 14..4 of the cycle count spanning 64 rising edges of the filtered horizontal input, which is 4*P for P below 512.
- R3: With a steady frame period F, `vperiod_o` equals bits 13..5 of the cycle count between two successive rising edges of the selected vertical reference, which is F/32 rounded down. It changes only after such a measurement completes or the counter saturates.
- R4: `vsel_i`=1 selects `cvsync_i` for vertical timing and polarity and takes vertical presence from `cv_present_i`. `vsel_i`=0 selects `vsync_i` and its own presence detection.
- R5: While `v_present_o` is 1, `hperiod_o` changes only in the cycle after a rising edge of the filtered vertical reference, and then takes the most recent completed horizontal result.
- R6: While `v_present_o` is 0, `hperiod_o` loads each horizontal result as soon as its 64-line window completes.
- R7: Both counters stop at all ones. A channel whose counter saturates reports all ones as its result (2047 horizontal, 511 vertical).
- R8: A channel's presence flag clears when its counter saturates. It sets again on the second rising edge after that, and not on the first.
- R9: `h_pol_o` / `v_pol_o` is 1 when the high time of the last full period was shorter than the low time, and 0 otherwise. It changes only on a rising edge of that channel's filtered input.
- R10: During reset all outputs driven by registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| vsync_i | input | 1 | Dedicated vertical sync, asynchronous |
| cvsync_i | input | 1 | Vertical pulse extracted from composite sync |
| vsel_i | input | 1 | 1: use composite vertical, 0: dedicated vertical |
| cv_present_i | input | 1 | Composite vertical present flag from separator |
| hperiod_o | output | 11 | Horizontal period result, top bits of 64-line count |
| vperiod_o | output | 9 | Vertical period result, top bits of frame count |
| h_present_o | output | 1 | Horizontal sync present |
| v_present_o | output | 1 | Selected vertical reference present |
| h_pol_o | output | 1 | Horizontal polarity, 1 = active-high pulses |
| v_pol_o | output | 1 | Vertical polarity, 1 = active-high pulses |

## Verification
A level change reaches the filtered signal four cycles after it is applied. A horizontal result reaches `hperiod_o` one cycle after its trigger, and a vertical result reaches `vperiod_o` two cycles after the frame edge. Since a change of period leaves the window in progress mixed, the bench waits at least two full windows or three frames after any change before it samples, always on the falling clock edge. The frame-gating check samples after two horizontal windows have ended but before the next vertical edge, then again twenty cycles past that edge. The presence checks sample twenty cycles after each single edge.

// File: rtl/sync_meas_pkg.sv
package sync_meas_pkg;
  typedef struct packed {
    logic present;
    logic pol;
  } chan_flags_t;
endpackage

// File: rtl/sync_meas_filter.sv
module sync_meas_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic lvl_o,
  output logic rise_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, lvl_q, rise_q;
  logic agree;

  assign agree = (sync_q[MSB] == prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], sig_i};
      prev_q <= sync_q[MSB];
      if (agree) lvl_q <= prev_q;
      rise_q <= agree && prev_q && !lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
endmodule

// File: rtl/sync_meas_chan.sv
module sync_meas_chan
  import sync_meas_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int RES_W = 11,
  parameter int WIN   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             rise_i,
  output logic [RES_W-1:0] res_o,
  output logic             done_o,
  output chan_flags_t      flags_o
);
  localparam int SEG_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(WIN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_MAX - CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, hi_q, lo_q;
  logic [SEG_W-1:0] seg_q;
  logic [RES_W-1:0] res_q;
  logic armed_q, done_q, present_q, pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      seg_q     <= '0;
      res_q     <= '0;
      armed_q   <= 1'b0;
      done_q    <= 1'b0;
      present_q <= 1'b0;
      pol_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rise_i) begin
        hi_q <= CNT_W'(1);
        lo_q <= '0;
        if (!armed_q) begin
          armed_q <= 1'b1;
          seg_q   <= '0;
          cnt_q   <= CNT_W'(1);
        end else begin
          present_q <= 1'b1;
          pol_q     <= (hi_q < lo_q);
          if (seg_q == SEG_LAST) begin
            res_q  <= cnt_q[CNT_W-1 -: RES_W];
            done_q <= 1'b1;
            seg_q  <= '0;
            cnt_q  <= CNT_W'(1);
          end else begin
            seg_q <= seg_q + SEG_W'(1);
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end else begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
        // lost sync: report maximum once, drop presence
        if (cnt_q == CNT_PRE) begin
          res_q     <= '1;
          done_q    <= 1'b1;
          present_q <= 1'b0;
          armed_q   <= 1'b0;
        end
        if (lvl_i) begin
          if (hi_q != CNT_MAX) hi_q <= hi_q + CNT_W'(1);
        end else begin
          if (lo_q != CNT_MAX) lo_q <= lo_q + CNT_W'(1);
        end
      end
    end
  end

  assign res_o           = res_q;
  assign done_o          = done_q;
  assign flags_o.present = present_q;
  assign flags_o.pol     = pol_q;
endmodule

// File: rtl/sync_meas.sv
module sync_meas
  import sync_meas_pkg::*;
#(
  parameter int H_CNT_W     = 15,
  parameter int H_RES_W     = 11,
  parameter int H_WIN       = 64,
  parameter int V_CNT_W     = 14,
  parameter int V_RES_W     = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               cvsync_i,
  input  logic               vsel_i,
  input  logic               cv_present_i,
  output logic [H_RES_W-1:0] hperiod_o,
  output logic [V_RES_W-1:0] vperiod_o,
  output logic               h_present_o,
  output logic               v_present_o,
  output logic               h_pol_o,
  output logic               v_pol_o
);
  logic h_lvl, h_rise, v_lvl, v_rise, v_src;
  logic h_done, v_done, h_trig;
  logic [H_RES_W-1:0] h_res, hper_q;
  logic [V_RES_W-1:0] v_res, vper_q;
  chan_flags_t h_flags, v_flags;

  assign v_src = vsel_i ? cvsync_i : vsync_i;

  sync_meas_filter #(.SYNC_STAGES(SYNC_STAGES)) u_hflt (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(hsync_i), .lvl_o(h_lvl), .rise_o(h_rise)
  );

  sync_meas_filter #(.SYNC_STAGES(SYNC_STAGES)) u_vflt (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(v_src), .lvl_o(v_lvl), .rise_o(v_rise)
  );

  sync_meas_chan #(.CNT_W(H_CNT_W), .RES_W(H_RES_W), .WIN(H_WIN)) u_hchan (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(h_lvl), .rise_i(h_rise),
    .res_o(h_res), .done_o(h_done), .flags_o(h_flags)
  );

  sync_meas_chan #(.CNT_W(V_CNT_W), .RES_W(V_RES_W), .WIN(1)) u_vchan (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(v_lvl), .rise_i(v_rise),
    .res_o(v_res), .done_o(v_done), .flags_o(v_flags)
  );

  assign v_present_o = vsel_i ? cv_present_i : v_flags.present;
  // frame-locked update when vertical is present, free-running otherwise
  assign h_trig = v_present_o ? v_rise : h_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hper_q <= '0;
      vper_q <= '0;
    end else begin
      if (h_trig) hper_q <= h_res;
      if (v_done) vper_q <= v_res;
    end
  end

  assign hperiod_o   = hper_q;
  assign vperiod_o   = vper_q;
  assign h_present_o = h_flags.present;
  assign h_pol_o     = h_flags.pol;
  assign v_pol_o     = v_flags.pol;
endmodule

// File: rtl/sync_meas_chk.sv
module sync_meas_chk #(
  parameter int H_RES_W = 11,
  parameter int V_RES_W = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               hsync_i,
  input logic [H_RES_W-1:0] hperiod_o,
  input logic [V_RES_W-1:0] vperiod_o,
  input logic               h_present_o,
  input logic               v_present_o,
  input logic               h_pol_o,
  input logic               h_lvl,
  input logic               h_rise,
  input logic               h_done,
  input logic               v_rise,
  input logic               v_done
);
  AST_FLT_TWO_SAMPLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(h_lvl) |-> ($past(hsync_i, 3) && $past(hsync_i, 4))); // R1

  AST_VPER_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_done |=> $stable(vperiod_o)); // R3

  AST_HPER_FRAME_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_present_o && !v_rise) |=> $stable(hperiod_o)); // R5

  AST_HPER_FREE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!v_present_o && !h_done) |=> $stable(hperiod_o)); // R6

  AST_PRESENT_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(h_present_o) |-> $past(h_rise)); // R8

  AST_POL_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_rise |=> $stable(h_pol_o)); // R9
endmodule

bind sync_meas sync_meas_chk #(.H_RES_W(H_RES_W), .V_RES_W(V_RES_W)) chk_i (.*);

// File: tb/sync_meas_tb_top.sv
module sync_meas_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni;
  logic hsync_i = 1'b0, vsync_i = 1'b0, cvsync_i = 1'b0;
  logic vsel_i, cv_present_i;
  logic [10:0] hperiod_o;
  logic [8:0]  vperiod_o;
  logic h_present_o, v_present_o, h_pol_o, v_pol_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // waveform controls
  bit h_run = 0, v_run = 0, cv_run = 0;
  logic h_idle = 1'b0, v_idle = 1'b0, cv_idle = 1'b0;
  logic h_act = 1'b0, v_act = 1'b0, cv_act = 1'b0;
  bit h_glitch = 0;
  int h_per = 20, h_w = 4, h_ph = 0;
  int v_per = 6000, v_w = 40, v_ph = 0;
  int cv_per = 4000, cv_w = 30, cv_ph = 0;

  always #2.5 clk_i = ~clk_i;

  sync_meas dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .cvsync_i(cvsync_i), .vsel_i(vsel_i), .cv_present_i(cv_present_i),
    .hperiod_o(hperiod_o), .vperiod_o(vperiod_o), .h_present_o(h_present_o),
    .v_present_o(v_present_o), .h_pol_o(h_pol_o), .v_pol_o(v_pol_o)
  );

  function automatic int exp_h(int p);
    int c = 64 * p;
    if (c > 32767) c = 32767;
    return c >> 4;
  endfunction

  function automatic int exp_v(int p);
    int c = p;
    if (c > 16383) c = 16383;
    return c >> 5;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial forever begin
    @(negedge clk_i);
    if (h_run) begin
      h_ph = (h_ph + 1 >= h_per) ? 0 : h_ph + 1;
      hsync_i = ((h_ph < h_w) ? h_act : ~h_act) ^ (h_glitch && (h_ph == h_per / 2));
    end else hsync_i = h_idle;
  end

  initial forever begin
    @(negedge clk_i);
    if (v_run) begin
      v_ph = (v_ph + 1 >= v_per) ? 0 : v_ph + 1;
      vsync_i = (v_ph < v_w) ? v_act : ~v_act;
    end else vsync_i = v_idle;
  end

  initial forever begin
    @(negedge clk_i);
    if (cv_run) begin
      cv_ph = (cv_ph + 1 >= cv_per) ? 0 : cv_ph + 1;
      cvsync_i = (cv_ph < cv_w) ? cv_act : ~cv_act;
    end else cvsync_i = cv_idle;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    rst_ni = 1'b0;
    vsel_i = 1'b0;
    cv_present_i = 1'b0;
    wait_cyc(5);
    // R10 reset state
    chk("R10 hperiod", hperiod_o, 0);
    chk("R10 vperiod", vperiod_o, 0);
    chk("R10 h_present", h_present_o, 0);
    chk("R10 v_present", v_present_o, 0);
    chk("R10 h_pol", h_pol_o, 0);
    chk("R10 v_pol", v_pol_o, 0);
    rst_ni = 1'b1;

    // R2 R6 R9: random line timing, vertical absent
    h_run = 1;
    for (int k = 0; k < 4; k++) begin
      int p, w;
      p = $urandom_range(100, 16);
      w = $urandom_range(p / 3, 2);
      h_act = 1'($urandom_range(1, 0));
      h_w = w;
      h_per = p;
      wait_cyc(2 * 64 * p + 200);
      chk("R2/R6 hperiod", hperiod_o, exp_h(p));
      chk("R9 h_pol", h_pol_o, h_act);
      chk("R8 h_present", h_present_o, 1);
    end

    // R1: single-cycle glitch in the inactive phase of every line
    h_act = 1'b0; h_w = 8; h_per = 50; h_glitch = 1;
    wait_cyc(2 * 64 * 50 + 200);
    chk("R1 hperiod with glitch", hperiod_o, exp_h(50));
    chk("R1 h_pol with glitch", h_pol_o, 0);
    h_glitch = 0;

    // R3: dedicated vertical, active low
    h_per = 20; h_w = 4;
    v_act = 1'b0; v_w = 40; v_per = 6000; v_run = 1;
    wait_cyc(3 * 6000 + 200);
    chk("R3 vperiod", vperiod_o, exp_v(6000));
    chk("R9 v_pol", v_pol_o, 0);
    chk("R8 v_present", v_present_o, 1);
    chk("R5 hperiod steady", hperiod_o, exp_h(20));

    // R5: change line period just after a frame edge
    while (v_ph != 60) @(negedge clk_i);
    h_per = 30; h_w = 6;
    wait_cyc(4000);
    chk("R5 hperiod held until frame edge", hperiod_o, exp_h(20));
    while (v_ph != 60) @(negedge clk_i);
    chk("R5 hperiod after frame edge", hperiod_o, exp_h(30));

    // R4: composite vertical selected, dedicated input still toggling
    vsel_i = 1'b1; cv_present_i = 1'b1;
    cv_act = 1'b1; cv_w = 30; cv_per = 4000; cv_run = 1;
    wait_cyc(3 * 4000 + 200);
    chk("R4 vperiod from composite", vperiod_o, exp_v(4000));
    chk("R4 v_pol from composite", v_pol_o, 1);
    chk("R4 v_present from flag", v_present_o, 1);
    cv_present_i = 1'b0;
    wait_cyc(5);
    chk("R4 v_present follows flag", v_present_o, 0);

    // R6: free-running horizontal update with vertical flagged absent
    h_act = 1'b1; h_w = 5; h_per = 25;
    wait_cyc(2 * 64 * 25 + 200);
    chk("R6 hperiod free-run", hperiod_o, exp_h(25));

    // R7 R8: all syncs stop
    h_idle = 1'b1; h_run = 0;
    cv_idle = 1'b0; cv_run = 0;
    wait_cyc(33500);
    chk("R7 hperiod saturated", hperiod_o, 2047);
    chk("R7 vperiod saturated", vperiod_o, 511);
    chk("R8 h_present cleared", h_present_o, 0);

    // R8: presence needs two edges
    h_idle = 1'b0; wait_cyc(10);
    h_idle = 1'b1; wait_cyc(20);
    chk("R8 h_present after one edge", h_present_o, 0);
    h_idle = 1'b0; wait_cyc(10);
    h_idle = 1'b1; wait_cyc(20);
    chk("R8 h_present after two edges", h_present_o, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule